// File: doc/BRIEF.md
# Four-Mode Addressable Sink Latch

This block holds eight single-bit entries and drives one low-side sink control per entry. Each cycle, two active-low controls, `clr_n_i` and `en_n_i`, pick one of four modes. In latch mode one entry is written through a 3-bit binary select. Hold mode freezes everything. Demultiplexer mode routes the data bit to one output and forces all the others off. Clear mode turns every output off.

Every output comes in two forms. `sink_on_o` is high when the driver would conduct. `pin_level_o` is its complement, which models the level seen on an open-drain pin with a pull-up.

The block is a clocked rendering of level-sensitive behaviour. The inputs are sampled on each rising edge of `clk_i`, and the outputs change one register stage later. Callers should keep `en_n_i` high while `sel_i` is moving, so that an address in transit is never written.

Top module: `addr_sink_latch`

## Requirements
- R1: `sel_i` addresses an entry in plain binary: value k selects entry k, which drives bit k of both output vectors (0 picks bit 0, 7 picks bit 7).
- R2: In latch mode (`clr_n_i`=1, `en_n_i`=0), the addressed entry takes `din_i` after the edge, and the other seven entries keep their values.
- R3: In hold mode (`clr_n_i`=1, `en_n_i`=1), no output changes across the edge, whatever `sel_i` and `din_i` are.
- R4: In demultiplexer mode (`clr_n_i`=0, `en_n_i`=0), after the edge the addressed entry equals `din_i` and every other entry is 0.
- R5: In clear mode (`clr_n_i`=0, `en_n_i`=1), all entries are 0 after the edge, whatever `sel_i` and `din_i` are.
- R6: `pin_level_o` is always the bitwise inverse of `sink_on_o`, so a stored 1 gives a low pin level.
- R7: The synchronous reset `rst_i` zeroes all entries on the edge and takes priority over every mode.
- R8: The state left by demultiplexer or clear mode persists: a following hold cycle shows exactly that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 3 | Binary entry select |
| din_i | input | 1 | Data bit |
| en_n_i | input | 1 | Enable, active low |
| clr_n_i | input | 1 | Clear control, active low |
| sink_on_o | output | 8 | 1 = sink driver conducting, one bit per entry |
| pin_level_o | output | 8 | Modelled pin level, inverse of sink_on_o |

## Verification
The outputs are the stored entries themselves, with no logic in between. A wrong bit in an entry therefore appears on `sink_on_o` and `pin_level_o` in the very cycle after the faulty edge. The bench compares all eight bits after every edge.

A slip in mode decoding shows up as unaddressed bits changing in latch mode, or as surviving bits after a demultiplexer or clear cycle. A hold cycle that follows exposes the same error again. A fault in select decoding moves a written bit to the wrong position.

// File: rtl/asl_pkg.sv
package asl_pkg;

    // Operating mode picked by the two active-low controls
    typedef enum logic [1:0] {
        MODE_LATCH = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } asl_mode_e;

endpackage

// File: rtl/asl_mode_dec.sv
module asl_mode_dec
    import asl_pkg::*;
(
    input  logic      clr_n_i,
    input  logic      en_n_i,
    output asl_mode_e mode_o
);

    always_comb begin
        unique case ({clr_n_i, en_n_i})
            2'b10:   mode_o = MODE_LATCH;
            2'b11:   mode_o = MODE_HOLD;
            2'b00:   mode_o = MODE_DEMUX;
            default: mode_o = MODE_CLEAR;
        endcase
    end

endmodule

// File: rtl/asl_sel_dec.sv
module asl_sel_dec #(
    parameter int N_ENTRIES = 8,
    parameter int SEL_W     = $clog2(N_ENTRIES)
) (
    input  logic [SEL_W-1:0]     sel_i,
    output logic [N_ENTRIES-1:0] hit_o
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_hit
        assign hit_o[i] = (sel_i == SEL_W'(i));
    end

endmodule

// File: rtl/asl_next_calc.sv
module asl_next_calc
    import asl_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  asl_mode_e            mode_i,
    input  logic [N_ENTRIES-1:0] hit_i,
    input  logic                 din_i,
    input  logic [N_ENTRIES-1:0] cur_i,
    output logic [N_ENTRIES-1:0] nxt_o
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        logic bit_d;
        always_comb begin
            unique case (mode_i)
                MODE_LATCH: bit_d = hit_i[i] ? din_i : cur_i[i];
                MODE_HOLD:  bit_d = cur_i[i];
                MODE_DEMUX: bit_d = hit_i[i] & din_i;
                default:    bit_d = 1'b0;
            endcase
        end
        assign nxt_o[i] = bit_d;
    end

endmodule

// File: rtl/addr_sink_latch.sv
module addr_sink_latch
    import asl_pkg::*;
#(
    parameter  int N_ENTRIES = 8,
    localparam int SEL_W     = $clog2(N_ENTRIES)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic                 din_i,
    input  logic                 en_n_i,
    input  logic                 clr_n_i,
    output logic [N_ENTRIES-1:0] sink_on_o,
    output logic [N_ENTRIES-1:0] pin_level_o
);

    typedef struct packed {
        logic [N_ENTRIES-1:0] store;
    } state_t;

    state_t               st_d, st_q;
    asl_mode_e            mode;
    logic [N_ENTRIES-1:0] hit;
    logic [N_ENTRIES-1:0] entry_nxt;

    asl_mode_dec u_mode (
        .clr_n_i (clr_n_i),
        .en_n_i  (en_n_i),
        .mode_o  (mode)
    );

    asl_sel_dec #(.N_ENTRIES(N_ENTRIES), .SEL_W(SEL_W)) u_sel (
        .sel_i (sel_i),
        .hit_o (hit)
    );

    asl_next_calc #(.N_ENTRIES(N_ENTRIES)) u_next (
        .mode_i (mode),
        .hit_i  (hit),
        .din_i  (din_i),
        .cur_i  (st_q.store),
        .nxt_o  (entry_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.store = '0;
        end else begin
            st_d.store = entry_nxt;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sink_on_o   = st_q.store;
    assign pin_level_o = ~st_q.store;

endmodule

// File: rtl/asl_chk.sv
module asl_chk #(
    parameter  int N_ENTRIES = 8,
    localparam int SEL_W     = $clog2(N_ENTRIES)
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic [SEL_W-1:0]     sel_i,
    input logic                 din_i,
    input logic                 en_n_i,
    input logic                 clr_n_i,
    input logic [N_ENTRIES-1:0] sink_on_o,
    input logic [N_ENTRIES-1:0] pin_level_o
);

    localparam logic [N_ENTRIES-1:0] ONE = N_ENTRIES'(1);

    p_latch_others_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_n_i && !en_n_i) |=>
        ((sink_on_o & ~(ONE << $past(sel_i))) == ($past(sink_on_o) & ~(ONE << $past(sel_i)))));

    p_latch_target_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_n_i && !en_n_i) |=> (sink_on_o[$past(sel_i)] == $past(din_i)));

    p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_n_i && en_n_i) |=> $stable(sink_on_o));

    p_demux_only_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_n_i && !en_n_i) |=>
        (sink_on_o == ($past(din_i) ? (ONE << $past(sel_i)) : '0)));

    p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_n_i && en_n_i) |=> (sink_on_o == '0));

    p_pin_inverse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (pin_level_o == ~sink_on_o));

    p_reset_zero_r7: assert property (@(posedge clk_i)
        rst_i |=> (sink_on_o == '0));

endmodule

bind addr_sink_latch asl_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .sel_i       (sel_i),
    .din_i       (din_i),
    .en_n_i      (en_n_i),
    .clr_n_i     (clr_n_i),
    .sink_on_o   (sink_on_o),
    .pin_level_o (pin_level_o)
);

// File: tb/tb_addr_sink_latch.sv
module tb_addr_sink_latch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = '0;
    logic       din = 1'b0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] sink_on;
    logic [7:0] pin_level;

    logic [7:0] model = '0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    addr_sink_latch dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .sel_i       (sel),
        .din_i       (din),
        .en_n_i      (en_n),
        .clr_n_i     (clr_n),
        .sink_on_o   (sink_on),
        .pin_level_o (pin_level)
    );

    function automatic logic [7:0] ref_next(logic [7:0] cur, logic r, logic c_n,
                                            logic e_n, logic [2:0] s, logic d);
        logic [7:0] m = 8'(1) << s;
        if (r) return '0;
        case ({c_n, e_n})
            2'b10:   return d ? (cur | m) : (cur & ~m);
            2'b11:   return cur;
            2'b00:   return d ? m : '0;
            default: return '0;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare 2 ns after the rising edge
    task automatic step(string tag, logic r, logic c_n, logic e_n, logic [2:0] s, logic d);
        @(negedge clk);
        rst = r; clr_n = c_n; en_n = e_n; sel = s; din = d;
        @(posedge clk);
        model = ref_next(model, r, c_n, e_n, s, d);
        #2;
        check(tag, sink_on, model);
        check("R6 pin inverse", pin_level, ~model);
    endtask

    function automatic string mode_tag(logic c_n, logic e_n);
        case ({c_n, e_n})
            2'b10:   return "R2 latch";
            2'b11:   return "R3 hold";
            2'b00:   return "R4 demux";
            default: return "R5 clear";
        endcase
    endfunction

    initial begin
        void'($urandom(32'd24681));
        step("R7 reset", 1, 1, 0, 3'd2, 1);
        step("R7 reset", 1, 1, 1, 3'd0, 0);
        // R1: walk a single 1 through every address
        for (int k = 0; k < 8; k++) begin
            step("R1 select", 0, 1, 0, 3'(k), 1);
            step("R1 select", 0, 1, 0, 3'(k), 0);
        end
        step("R2 latch", 0, 1, 0, 3'd0, 1);
        step("R2 latch", 0, 1, 0, 3'd7, 1);
        step("R2 latch", 0, 1, 0, 3'd3, 1);
        step("R2 latch", 0, 1, 0, 3'd7, 0);
        for (int k = 0; k < 8; k++) begin
            step("R3 hold", 0, 1, 1, 3'(k), k[0]);
        end
        step("R4 demux", 0, 0, 0, 3'd5, 1);
        step("R8 after demux", 0, 1, 1, 3'd1, 1);
        step("R4 demux zero", 0, 0, 0, 3'd2, 0);
        step("R8 after demux", 0, 1, 1, 3'd6, 1);
        step("R2 latch", 0, 1, 0, 3'd4, 1);
        step("R2 latch", 0, 1, 0, 3'd6, 1);
        step("R5 clear", 0, 0, 1, 3'd4, 1);
        step("R8 after clear", 0, 1, 1, 3'd4, 1);
        step("R2 latch", 0, 1, 0, 3'd1, 1);
        step("R7 reset priority", 1, 0, 0, 3'd1, 1);
        step("R3 hold", 0, 1, 1, 3'd1, 1);
        for (int n = 0; n < 600; n++) begin
            logic c_n = 1'($urandom);
            logic e_n = 1'($urandom);
            logic r   = ($urandom % 50) == 0;
            step(r ? "R7 random reset" : mode_tag(c_n, e_n), r, c_n, e_n,
                 3'($urandom), 1'($urandom));
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule